// File: doc/BRIEF.md
# ADC Result FIFO with Fill-Level DMA Triggers

This block holds tagged conversion results between a converter sequencer and the system bus. Each write stores a 20-bit result along with the 3-bit number of the slot that produced it. Entries leave in arrival order. The oldest entry is always presented as a packed 32-bit word. That word carries the result, the number of valid entries and the slot tag.

Software reads the FIFO through two views, selected by a one-bit read address.
- View 0 is a look-only view.
- View 1 consumes the entry, but only while destructive reads are enabled.

A separate DMA pop strobe lets a transfer engine drain the FIFO. That engine sees its own copy of the word, and a mask option can strip that copy down to the result field alone.

Two fill conditions are flagged: three-quarters full and completely full. Each condition raises a DMA request when its enable bit is set. A sticky status bit records each request until software clears it. A write that finds the FIFO full is discarded and latches an overflow indication.

Top module: `adc_result_fifo`

## Requirements
- R1: `rd_word_o` packs the oldest entry as follows:
  - result in bits [19:0];
  - valid entry count (including that entry) in bits [27:20];
  - slot tag in bits [30:28];
  - bit 31 always 0.
- R2: Entries are returned in the order they were written, up to DEPTH (16) entries.
- R3: A read with `rd_addr_i`=0 never removes an entry.
- R4: A read with `rd_addr_i`=1 removes the oldest entry only when `destr_en_i`=1; with `destr_en_i`=0 the FIFO is unchanged.
- R5: `fill75_o` is 1 when the count is at least 12 (three quarters of DEPTH). `full_o` is 1 when the count equals 16.
- R6: `dma_req_o[0]` equals `trig_en_i[0]` AND three-quarters full. `dma_req_o[1]` equals `trig_en_i[1]` AND full.
- R7: `dma_stat_o[i]` is set on the clock edge after `dma_req_o[i]` is high. It stays set until a cycle with `stat_clr_i[i]`=1 and no request. A new request wins over a clear.
- R8: With `dma_mask_i`=1, `dma_word_o` holds only the result in bits [19:0], with bits [31:20] zero. With `dma_mask_i`=0 it equals `rd_word_o`.
- R9: A write while full is dropped, and `ovf_o` is set. `ovf_o` stays set until `ovf_clr_i` is applied with no new dropped write.
- R10: A pop while empty has no effect, and `rd_word_o` reads as all zeros while empty.
- R11: A push and a pop in the same cycle on a non-empty, non-full FIFO leave the count unchanged.
- R12: `dma_pop_i` removes the oldest entry regardless of `destr_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write a result this cycle |
| wr_data_i | input | 20 | Conversion result |
| wr_slot_i | input | 3 | Slot tag of the result |
| rd_en_i | input | 1 | Software read strobe |
| rd_addr_i | input | 1 | Read view: 0 look-only, 1 consuming |
| destr_en_i | input | 1 | Allows view 1 to consume |
| dma_pop_i | input | 1 | DMA consumes the oldest entry |
| dma_mask_i | input | 1 | Strip count and slot from DMA word |
| trig_en_i | input | 2 | Request enables: bit 0 three-quarters, bit 1 full |
| stat_clr_i | input | 2 | Clears for the sticky request status bits |
| ovf_clr_i | input | 1 | Clears the overflow indication |
| rd_word_o | output | 32 | Packed oldest entry for software |
| dma_word_o | output | 32 | Packed oldest entry for DMA |
| count_o | output | CNT_W (5) | Number of valid entries |
| fill75_o | output | 1 | Three-quarters-full flag |
| full_o | output | 1 | Full flag |
| dma_req_o | output | 2 | DMA requests: bit 0 three-quarters, bit 1 full |
| dma_stat_o | output | 2 | Sticky record of requests |
| ovf_o | output | 1 | Sticky dropped-write indication |

## Verification
The bench builds the block with the default DEPTH of 16, which makes the threshold 12. It walks the count through the threshold edge at 11 and 12, then to the full point of 16, and writes once more past full. It also drains the FIFO back to empty.

All reachable fill states are visited at this depth. Together they cover:
- both request levels;
- the dropped write;
- the empty pop;
- wrap-around of both pointers, with the order kept across the wrap.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int RES_W     = 20;
  localparam int SLOT_W    = 3;
  localparam int CNT_F_W   = 8;
  localparam int WORD_W    = 32;
  localparam int CNT_LSB   = RES_W;
  localparam int SLOT_LSB  = CNT_LSB + CNT_F_W;
  localparam int N_COND    = 2;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [RES_W-1:0]  data;
  } entry_t;

  function automatic logic [WORD_W-1:0] pack_word(entry_t e, logic [CNT_F_W-1:0] cnt,
                                                  logic strip);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RES_W-1:0] = e.data;
    if (!strip) begin
      w[CNT_LSB +: CNT_F_W] = cnt;
      w[SLOT_LSB +: SLOT_W] = e.slot;
    end
    return w;
  endfunction
endpackage

// File: rtl/fifo_store.sv
module fifo_store import adc_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  entry_t           entry_i,
  output entry_t           head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  entry_t           mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= entry_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/fifo_read_view.sv
module fifo_read_view import adc_fifo_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  entry_t            head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              empty_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  input  logic              destr_en_i,
  input  logic              dma_pop_i,
  input  logic              dma_mask_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [WORD_W-1:0] dma_word_o,
  output logic              pop_o
);
  logic [CNT_F_W-1:0] cnt_f;

  assign cnt_f = CNT_F_W'(count_i);

  // view 1 consumes only when destructive reads are allowed
  assign pop_o = (rd_en_i && rd_addr_i && destr_en_i) || dma_pop_i;

  always_comb begin
    if (empty_i) begin
      rd_word_o  = '0;
      dma_word_o = '0;
    end else begin
      rd_word_o  = pack_word(head_i, cnt_f, 1'b0);
      dma_word_o = pack_word(head_i, cnt_f, dma_mask_i);
    end
  end
endmodule

// File: rtl/fifo_fill_trig.sv
module fifo_fill_trig import adc_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_75 = (DEPTH * 3) / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [N_COND-1:0] trig_en_i,
  input  logic [N_COND-1:0] stat_clr_i,
  input  logic              wr_drop_i,
  input  logic              ovf_clr_i,
  output logic              fill75_o,
  output logic              full_o,
  output logic [N_COND-1:0] req_o,
  output logic [N_COND-1:0] stat_o,
  output logic              ovf_o
);
  logic [N_COND-1:0] cond;
  logic [N_COND-1:0] stat_q;
  logic              ovf_q;

  assign fill75_o = (count_i >= CNT_W'(THR_75));
  assign full_o   = (count_i == CNT_W'(DEPTH));
  assign cond     = {full_o, fill75_o};

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    assign req_o[g] = trig_en_i[g] && cond[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[g] <= 1'b0;
      else         stat_q[g] <= (stat_q[g] && !stat_clr_i[g]) || req_o[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= (ovf_q && !ovf_clr_i) || wr_drop_i;
  end

  assign stat_o = stat_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo import adc_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [RES_W-1:0]  wr_data_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  input  logic              destr_en_i,
  input  logic              dma_pop_i,
  input  logic              dma_mask_i,
  input  logic [N_COND-1:0] trig_en_i,
  input  logic [N_COND-1:0] stat_clr_i,
  input  logic              ovf_clr_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [WORD_W-1:0] dma_word_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              fill75_o,
  output logic              full_o,
  output logic [N_COND-1:0] dma_req_o,
  output logic [N_COND-1:0] dma_stat_o,
  output logic              ovf_o
);
  entry_t           wr_entry, head;
  logic [CNT_W-1:0] cnt;
  logic             st_full, st_empty, pop;

  assign wr_entry = '{slot: wr_slot_i, data: wr_data_i};

  fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_valid_i),
    .pop_i   (pop),
    .entry_i (wr_entry),
    .head_o  (head),
    .count_o (cnt),
    .full_o  (st_full),
    .empty_o (st_empty)
  );

  fifo_read_view #(.CNT_W(CNT_W)) u_view (
    .head_i     (head),
    .count_i    (cnt),
    .empty_i    (st_empty),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .destr_en_i (destr_en_i),
    .dma_pop_i  (dma_pop_i),
    .dma_mask_i (dma_mask_i),
    .rd_word_o  (rd_word_o),
    .dma_word_o (dma_word_o),
    .pop_o      (pop)
  );

  fifo_fill_trig #(.DEPTH(DEPTH)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (cnt),
    .trig_en_i  (trig_en_i),
    .stat_clr_i (stat_clr_i),
    .wr_drop_i  (wr_valid_i && st_full),
    .ovf_clr_i  (ovf_clr_i),
    .fill75_o   (fill75_o),
    .full_o     (full_o),
    .req_o      (dma_req_o),
    .stat_o     (dma_stat_o),
    .ovf_o      (ovf_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/adc_result_fifo_chk.sv
module adc_result_fifo_chk import adc_fifo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              rd_en_i,
  input logic              rd_addr_i,
  input logic              destr_en_i,
  input logic              dma_pop_i,
  input logic              dma_mask_i,
  input logic              ovf_clr_i,
  input logic [WORD_W-1:0] rd_word_o,
  input logic [WORD_W-1:0] dma_word_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              full_o,
  input logic [N_COND-1:0] dma_req_o,
  input logic [N_COND-1:0] dma_stat_o,
  input logic              ovf_o
);
  p_top_bit_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word_o[WORD_W-1] == 1'b0);

  p_count_field_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word_o[CNT_LSB +: CNT_F_W] == CNT_F_W'(count_o));

  p_peek_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_addr_i && !dma_pop_i && !wr_valid_i) |=> $stable(count_o));

  p_no_destr_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i && !destr_en_i && !dma_pop_i && !wr_valid_i) |=> $stable(count_o));

  p_req_sets_stat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o[0] |=> dma_stat_o[0]);

  p_req_sets_stat_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o[1] |=> dma_stat_o[1]);

  p_mask_strips_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mask_i |-> (dma_word_o[WORD_W-1:RES_W] == '0));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_valid_i) |=> ovf_o);

  p_full_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_valid_i && !dma_pop_i && !(rd_en_i && rd_addr_i && destr_en_i))
      |=> $stable(count_o));

  p_empty_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_word_o == '0));

  p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
endmodule

bind adc_result_fifo adc_result_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .destr_en_i (destr_en_i),
  .dma_pop_i  (dma_pop_i),
  .dma_mask_i (dma_mask_i),
  .ovf_clr_i  (ovf_clr_i),
  .rd_word_o  (rd_word_o),
  .dma_word_o (dma_word_o),
  .count_o    (count_o),
  .full_o     (full_o),
  .dma_req_o  (dma_req_o),
  .dma_stat_o (dma_stat_o),
  .ovf_o      (ovf_o)
);

// File: tb/adc_result_fifo_bench.sv
module adc_result_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 0, rd_en = 0, rd_addr = 0, destr_en = 0;
  logic        dma_pop = 0, dma_mask = 0, ovf_clr = 0;
  logic [19:0] wr_data = '0;
  logic [2:0]  wr_slot = '0;
  logic [1:0]  trig_en = '0, stat_clr = '0;
  logic [31:0] rd_word, dma_word;
  logic [CNT_W-1:0] count;
  logic        fill75, full, ovf;
  logic [1:0]  dma_req, dma_stat;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [22:0] model_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_result_fifo #(.DEPTH(DEPTH)) u_adc_result_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_slot_i(wr_slot), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .destr_en_i(destr_en),
    .dma_pop_i(dma_pop), .dma_mask_i(dma_mask), .trig_en_i(trig_en),
    .stat_clr_i(stat_clr), .ovf_clr_i(ovf_clr), .rd_word_o(rd_word),
    .dma_word_o(dma_word), .count_o(count), .fill75_o(fill75), .full_o(full),
    .dma_req_o(dma_req), .dma_stat_o(dma_stat), .ovf_o(ovf)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    if (model_q.size() == 0) return 32'h0;
    return {1'b0, model_q[0][22:20], 8'(model_q.size()), model_q[0][19:0]};
  endfunction

  // one clock: drive now (at negedge), update model, return at next negedge
  task automatic step(bit push, logic [19:0] d, logic [2:0] s, bit ren, bit addr, bit dpop);
    bit pop_eff, push_eff;
    wr_valid = push; wr_data = d; wr_slot = s;
    rd_en = ren; rd_addr = addr; dma_pop = dpop;
    pop_eff  = ((ren && addr && destr_en) || dpop) && model_q.size() > 0;
    push_eff = push && model_q.size() < DEPTH;
    @(negedge clk);
    wr_valid = 0; rd_en = 0; rd_addr = 0; dma_pop = 0;
    if (pop_eff)  void'(model_q.pop_front());
    if (push_eff) model_q.push_back({s, d});
  endtask

  task automatic push(logic [19:0] d, logic [2:0] s);
    step(1, d, s, 0, 0, 0);
  endtask

  task automatic t_reset();
    check("R10", "count after reset", 32'(count), 0);
    check("R10", "rd_word after reset", rd_word, 0);
    check("R5", "flags after reset", {30'b0, full, fill75}, 0);
    check("R9", "ovf after reset", 32'(ovf), 0);
  endtask

  task automatic t_layout();
    push(20'hABCDE, 3'd5);
    push(20'h12345, 3'd2);
    push(20'h00F0F, 3'd7);
    check("R1", "packed word", rd_word, {1'b0, 3'd5, 8'd3, 20'hABCDE});
    check("R1", "model word", rd_word, exp_word());
  endtask

  task automatic t_peek();
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    check("R3", "count after view-0 reads", 32'(count), 3);
    check("R3", "word after view-0 reads", rd_word, exp_word());
  endtask

  task automatic t_pop_ctrl();
    destr_en = 0;
    step(0, 0, 0, 1, 1, 0);
    check("R4", "count with destructive off", 32'(count), 3);
    destr_en = 1;
    step(0, 0, 0, 1, 1, 0);
    check("R4", "count with destructive on", 32'(count), 2);
    check("R2", "next head", rd_word, {1'b0, 3'd2, 8'd2, 20'h12345});
    destr_en = 0;
  endtask

  task automatic t_fill75();
    for (int i = 0; i < 9; i++) push(20'(i * 7 + 1), 3'(i));
    check("R5", "count 11 below threshold", 32'(fill75), 0);
    push(20'hCAFE0, 3'd6);
    check("R5", "fill75 at 12", 32'(fill75), 1);
    check("R5", "full at 12", 32'(full), 0);
    check("R6", "no request when disabled", 32'(dma_req), 0);
    trig_en = 2'b01;
    #1;
    check("R6", "75 request", 32'(dma_req), 32'b01);
    step(0, 0, 0, 0, 0, 0);
    check("R7", "sticky 75 status", 32'(dma_stat), 32'b01);
    trig_en = 2'b00;
    step(0, 0, 0, 0, 0, 0);
    check("R7", "status holds without clear", 32'(dma_stat), 32'b01);
    stat_clr = 2'b01;
    step(0, 0, 0, 0, 0, 0);
    stat_clr = 2'b00;
    check("R7", "status cleared", 32'(dma_stat), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) push(20'(16'hBEE0 + i), 3'(i + 1));
    check("R5", "full at 16", 32'(full), 1);
    trig_en = 2'b10;
    #1;
    check("R6", "full request", 32'(dma_req), 32'b10);
    push(20'h55555, 3'd3);
    check("R9", "count after dropped write", 32'(count), DEPTH);
    check("R9", "ovf set", 32'(ovf), 1);
    check("R9", "head unchanged", rd_word, exp_word());
    check("R7", "full status", 32'(dma_stat[1]), 1);
    trig_en = 2'b00;
    ovf_clr = 1; stat_clr = 2'b11;
    step(0, 0, 0, 0, 0, 0);
    ovf_clr = 0; stat_clr = 2'b00;
    check("R9", "ovf cleared", 32'(ovf), 0);
  endtask

  task automatic t_mask();
    dma_mask = 1;
    #1;
    check("R8", "masked dma word", dma_word, {12'h000, model_q[0][19:0]});
    dma_mask = 0;
    #1;
    check("R8", "unmasked dma word", dma_word, rd_word);
    destr_en = 0;
    step(0, 0, 0, 0, 0, 1);
    check("R12", "dma pop ignores destr_en", 32'(count), DEPTH - 1);
    check("R12", "head after dma pop", rd_word, exp_word());
  endtask

  task automatic t_simul();
    step(1, 20'h0DEAD, 3'd4, 0, 0, 1);
    check("R11", "count on push+pop", 32'(count), DEPTH - 1);
    check("R11", "head on push+pop", rd_word, exp_word());
  endtask

  task automatic t_drain();
    int errs = 0;
    while (model_q.size() > 0) begin
      step(0, 0, 0, 0, 0, 1);
      if (rd_word !== exp_word()) errs++;
    end
    check("R2", "order across wrap (mismatches)", 32'(errs), 0);
    check("R10", "count empty", 32'(count), 0);
    destr_en = 1;
    step(0, 0, 0, 1, 1, 0);
    check("R10", "count after empty pop", 32'(count), 0);
    check("R10", "word while empty", rd_word, 0);
    destr_en = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_peek();
    t_pop_ctrl();
    t_fill75();
    t_full();
    t_mask();
    t_simul();
    t_drain();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule